// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine

This block computes a 16-bit cyclic redundancy check over a byte sequence that software feeds one byte per register write. Each write to the feed register folds that byte into a 16-bit remainder in a single clock and increments a 12-bit count of processed bytes. The finished checksum is read from its own result register. The processed-byte count is read from the low bits of the control register.

The same control register carries a clear bit. Writing it with the clear bit set puts the remainder back to its starting value and zeroes the count. The bit is self-clearing, so it never reads back as set. The arithmetic follows the reflected CCITT form: generator x^16+x^12+x^5+1, remainder preset to all ones, least significant data bit first, and the result inverted on the way out. With these settings the fixed power-on check vector gives the expected answer: after a clear, feeding 0xCC, 0xF5, 0xF1, 0xA7 yields a count of 4 and a result of 0x51DF.

The register port is a plain single-cycle bus. A write completes in the cycle where `wr_en` is high, and reads are combinational on `addr`. There is no back-pressure: every write is accepted, and a byte written in one cycle shows up in the result and count from the next cycle on.

Top module: `crc16_engine`

## Requirements
- R1: After `rst_n` is released, the count reads 0 and the result register reads 0x0000, which is the preset remainder 0xFFFF inverted.
- R2: A write to the control register (addr 0) with bit 15 set clears the count to 0 and restores the preset remainder, so the result reads 0x0000 on the next cycle.
- R3: A write to the control register with bit 15 clear changes neither the count nor the result. Bit 15 and bits 14:12 of the control register always read 0.
- R4: A write to the feed register (addr 1) adds one to the count and folds only `wdata[7:0]` into the remainder; `wdata[15:8]` has no effect on the result.
- R5: After a clear, feeding 0xCC, 0xF5, 0xF1, 0xA7 leaves the count at 4 and the result (addr 2) at 0x51DF.
- R6: The result equals the reflected CCITT CRC (polynomial 0x1021, preset 0xFFFF, bits taken LSB first, output XOR 0xFFFF). For the ASCII bytes "123456789" the result is 0x906E, for the single byte 0x00 it is 0xF078, and for the single byte 0xFF it is 0xFF00.
- R7: The count saturates at 4095 and stays there on further feed writes, while the remainder keeps updating.
- R8: The result and count reflect a feed write from the cycle after that write, with no extra latency.
- R9: Writes to the result register (addr 2) or to addr 3 change neither the count nor the result. Addr 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register selected by `addr` |
| addr | input | 2 | Register select: 0 control/count, 1 feed, 2 result, 3 unused |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for the register selected by `addr` |

## Verification
The engine is driven with several byte strings, each checked against a bit-serial reference model kept in the bench:
- The power-on check vector shows that the preset, reflection and output inversion are set as a group.
- The nine-digit ASCII string tests a longer run against a published check value.
- The single bytes 0x00 and 0xFF separate the effect of the preset from the effect of the data.
- A feed value with a non-zero upper byte shows whether the upper byte is masked.

A long stream of more than 4095 bytes exposes counter wrap-around and confirms that the remainder still tracks the data after the count stops. Control writes with the clear bit low, and writes to the result and unused addresses, show whether any of them disturbs the engine's state.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_FEED   = 2'd1,
    SEL_RESULT = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam int CLEAR_BIT = 15;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;

  function automatic logic [WORD_W-1:0] bit_reverse16(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) begin
      r[i] = v[WORD_W-1-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter logic [15:0] POLY    = 16'h1021,
  parameter bit          REFLECT = 1'b1
) (
  input  logic [15:0] crc_in,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc_out
);
  localparam logic [15:0] POLY_LSB = crc16_pkg::bit_reverse16(POLY);

  if (REFLECT) begin : g_lsb_first
    always_comb begin
      logic [15:0] acc;
      acc = crc_in;
      for (int i = 0; i < 8; i++) begin
        if (acc[0] ^ byte_in[i]) acc = (acc >> 1) ^ POLY_LSB;
        else                     acc = acc >> 1;
      end
      crc_out = acc;
    end
  end else begin : g_msb_first
    always_comb begin
      logic [15:0] acc;
      acc = crc_in;
      for (int i = 0; i < 8; i++) begin
        if (acc[15] ^ byte_in[7-i]) acc = (acc << 1) ^ POLY;
        else                        acc = acc << 1;
      end
      crc_out = acc;
    end
  end
endmodule

// File: rtl/crc16_sat_counter.sv
module crc16_sat_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clear)                count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/crc16_reg_port.sv
module crc16_reg_port #(
  parameter int CNT_W = 12
) (
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [15:0]      wdata,
  input  logic [CNT_W-1:0] count,
  input  logic [15:0]      result,
  output logic             clear_stb,
  output logic             feed_stb,
  output logic [7:0]       feed_byte,
  output logic [15:0]      rdata
);
  import crc16_pkg::*;
  localparam int PAD_W = 16 - CNT_W;

  reg_sel_e sel;
  assign sel       = reg_sel_e'(addr);
  assign clear_stb = wr_en && (sel == SEL_CTRL) && wdata[CLEAR_BIT];
  assign feed_stb  = wr_en && (sel == SEL_FEED);
  assign feed_byte = wdata[7:0];

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rdata = {{PAD_W{1'b0}}, count};
      SEL_RESULT: rdata = result;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine #(
  parameter logic [15:0] POLY    = 16'h1021,
  parameter logic [15:0] INIT    = 16'hFFFF,
  parameter logic [15:0] XOROUT  = 16'hFFFF,
  parameter bit          REFLECT = 1'b1,
  parameter int          CNT_W   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  logic             clear_stb;
  logic             feed_stb;
  logic [7:0]       feed_byte;
  logic [15:0]      rem_q;
  logic [15:0]      rem_next;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      result;

  crc16_reg_port #(.CNT_W(CNT_W)) u_port (
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .count     (cnt_q),
    .result    (result),
    .clear_stb (clear_stb),
    .feed_stb  (feed_stb),
    .feed_byte (feed_byte),
    .rdata     (rdata)
  );

  crc16_byte_step #(.POLY(POLY), .REFLECT(REFLECT)) u_step (
    .crc_in  (rem_q),
    .byte_in (feed_byte),
    .crc_out (rem_next)
  );

  crc16_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_stb),
    .inc   (feed_stb),
    .count (cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rem_q <= INIT;
    else if (clear_stb) rem_q <= INIT;
    else if (feed_stb)  rem_q <= rem_next;
  end

  assign result = rem_q ^ XOROUT;
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
  parameter int          CNT_W = 12,
  parameter logic [15:0] INIT  = 16'hFFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [15:0]      wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [15:0]      rem
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R2
  clear_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[15]) |=> (cnt == '0 && rem == INIT));

  // R3
  ctrl_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !wdata[15]) |=> ($stable(cnt) && $stable(rem)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  // R7
  count_hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !(wr_en && addr == 2'd0 && wdata[15])) |=> (cnt == TOP));

  // R9
  other_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || addr[1]) |=> ($stable(cnt) && $stable(rem)));
endmodule

bind crc16_engine crc16_engine_chk #(.CNT_W(CNT_W), .INIT(INIT)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .cnt   (cnt_q),
  .rem   (rem_q)
);

// File: tb/tb_crc16_engine.sv
`timescale 1ns/1ps
module tb_crc16_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  crc16_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  localparam int NV = 4;
  localparam logic [71:0] VEC_BYTES [NV] = '{
    72'hCCF5F1A7_0000000000,
    72'h31_32_33_34_35_36_37_38_39,
    72'h00_0000000000000000,
    72'hFF_0000000000000000
  };
  localparam int          VEC_LEN [NV] = '{4, 9, 1, 1};
  localparam logic [15:0] VEC_EXP [NV] = '{16'h51DF, 16'h906E, 16'hF078, 16'hFF00};

  function automatic logic [15:0] model_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = r[0] ^ b[k];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] model;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, v); check("R1 count", v, 16'h0000);
    reg_read(2'd2, v); check("R1 result", v, 16'h0000);

    // R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      reg_write(2'd0, 16'h8000);
      for (int j = 0; j < VEC_LEN[i]; j++) begin
        reg_write(2'd1, {8'h00, VEC_BYTES[i][71-8*j -: 8]});
      end
      reg_read(2'd0, v); check(i == 0 ? "R5 count" : "R6 count", v, 16'(VEC_LEN[i]));
      reg_read(2'd2, v); check(i == 0 ? "R5 result" : "R6 result", v, VEC_EXP[i]);
    end

    // R2 clear after data
    reg_write(2'd0, 16'h8000);
    reg_read(2'd0, v); check("R2 count", v, 16'h0000);
    reg_read(2'd2, v); check("R2 result", v, 16'h0000);

    // R4 upper byte ignored: 0xAB00 acts as byte 0x00
    reg_write(2'd1, 16'hAB00);
    reg_read(2'd2, v); check("R4 result", v, 16'hF078);
    reg_read(2'd0, v); check("R4 count", v, 16'h0001);

    // R3 control write with clear bit low; upper bits read 0
    reg_write(2'd0, 16'h7FFF);
    reg_read(2'd0, v); check("R3 count", v, 16'h0001);
    reg_read(2'd2, v); check("R3 result", v, 16'hF078);

    // R9 writes to result and spare addresses
    reg_write(2'd2, 16'h1234);
    reg_write(2'd3, 16'h8000);
    reg_read(2'd2, v); check("R9 result", v, 16'hF078);
    reg_read(2'd0, v); check("R9 count", v, 16'h0001);
    reg_read(2'd3, v); check("R9 spare", v, 16'h0000);

    // R8 back-to-back writes, result visible the cycle after each
    reg_write(2'd0, 16'h8000);
    model = 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 16'h005A;
    @(negedge clk);
    model = model_step(model, 8'h5A);
    wdata = 16'h00C3;
    @(negedge clk);
    model = model_step(model, 8'hC3);
    wr_en = 1'b0;
    reg_read(2'd2, v); check("R8 result", v, model ^ 16'hFFFF);
    reg_read(2'd0, v); check("R8 count", v, 16'h0002);

    // R7 saturation with continued CRC updates
    reg_write(2'd0, 16'h8000);
    model = 16'hFFFF;
    @(negedge clk);
    for (int n = 0; n < 4100; n++) begin
      wr_en = 1'b1; addr = 2'd1; wdata = 16'(n * 7 + 3);
      @(negedge clk);
      model = model_step(model, 8'(n * 7 + 3));
      if (n == 4093) begin
        wr_en = 1'b0;
        reg_read(2'd0, v); check("R7 count below top", v, 16'd4094);
      end
    end
    wr_en = 1'b0;
    reg_read(2'd0, v); check("R7 count saturated", v, 16'd4095);
    reg_read(2'd2, v); check("R7 result", v, model ^ 16'hFFFF);

    // R2 clear from saturation
    reg_write(2'd0, 16'hFFFF);
    reg_read(2'd0, v); check("R2 clear from top", v, 16'h0000);
    reg_read(2'd2, v); check("R2 result from top", v, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule